// File: doc/BRIEF.md
# Pipeline exception status tracker

This block follows the fault status of every instruction in a five-stage in-order pipeline and decides when that status may change architectural state. A status code is formed at fetch from the instruction-memory error, instruction-validity and halt-opcode flags. It then moves through four stage registers, one each for decode, execute, memory and write-back. Decode and execute forward the code untouched. The memory stage replaces it with an address fault when the data memory reports an error. A fault becomes visible as the processor status only once its instruction sits in the write-back register.

From the memory-stage and write-back codes, the block produces a few controls within the same cycle. It gates condition-code updates and data-memory writes from younger instructions. It drives bubbles into the memory register and freezes the write-back register so that the faulting instruction stays there. A sticky halted flag marks that the processor has left normal operation. The hazard unit can still insert bubbles into any stage register or stall it, through two four-bit request vectors.

Top module: `exc_status_tracker`

## Requirements
- R1: The fetch code follows a fixed priority. An instruction-memory error gives address fault (3). Otherwise an invalid instruction gives illegal (4). Otherwise a halt opcode gives halt (2). Otherwise the code is OK (1). Bubble is 0.
- R2: Decode and execute forward the code unchanged, so a fetch code reaches `stat_o` after the fourth rising edge when no stall or bubble is requested.
- R3: A data-memory error while an instruction is in the memory register makes that instruction's code address fault (3). Without the error the code passes through as it is.
- R4: `stat_o` equals the write-back code, except that a bubble (0) is shown as OK (1). Reset loads bubble into all four stage registers.
- R5: `set_cc_o` is high only when `e_aluop_i` is high and neither the memory-stage code nor the write-back code is halt, address fault or illegal. It changes in the same cycle as those codes.
- R6: While the memory-stage or write-back code is a fault, `m_bubble_o` is high, the memory register loads bubble at the next edge, and `dmem_we_o` is low. Otherwise `dmem_we_o` follows `m_wr_req_i`.
- R7: While the write-back code is a fault, `w_stall_o` is high and the write-back register keeps its code.
- R8: Hazard vector bit 0 selects decode, bit 1 execute, bit 2 memory and bit 3 write-back. A bubble request loads bubble into its register, a stall request holds the register, and bubble wins when both are requested.
- R9: `halted_o` goes high in the same cycle that `stat_o` differs from OK, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| imem_err_i | input | 1 | Instruction memory error at fetch |
| instr_valid_i | input | 1 | Fetched instruction code is legal |
| halt_op_i | input | 1 | Fetched instruction is a halt |
| dmem_err_i | input | 1 | Data memory error for the memory-stage access |
| e_aluop_i | input | 1 | Execute-stage instruction is an ALU operation |
| m_wr_req_i | input | 1 | Memory-stage instruction requests a write |
| hz_bubble_i | input | 4 | Bubble requests, bit 0 decode to bit 3 write-back |
| hz_stall_i | input | 4 | Stall requests, bit 0 decode to bit 3 write-back |
| set_cc_o | output | 1 | Condition-code update enable |
| dmem_we_o | output | 1 | Data memory write enable |
| m_bubble_o | output | 1 | Fault-driven bubble into the memory register |
| w_stall_o | output | 1 | Fault-driven hold of the write-back register |
| stat_o | output | 3 | Reported processor status |
| halted_o | output | 1 | Sticky flag for a status other than OK |

## Verification
A fetch code crosses four registers, so the bench checks `stat_o`, `w_stall_o` and `halted_o` just after the fourth rising edge that follows the fetch cycle. With stalls, each held edge adds one cycle to that count. The memory-stage results (`set_cc_o`, `dmem_we_o`, `m_bubble_o`) are combinational, so they are checked in the third cycle, right after the bench drives `dmem_err_i`. The bench drives inputs shortly after each rising edge and samples one time unit later, well before the next edge. One more edge is then checked to confirm that the code is held or cleared.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int STAT_W = 3;
   localparam int NREG   = 4;
   localparam int IDX_D  = 0;
   localparam int IDX_E  = 1;
   localparam int IDX_M  = 2;
   localparam int IDX_W  = 3;

   typedef enum logic [STAT_W-1:0] {
      ST_BUB = 3'd0,
      ST_AOK = 3'd1,
      ST_HLT = 3'd2,
      ST_ADR = 3'd3,
      ST_INS = 3'd4
   } stat_e;

   function automatic logic is_fault(stat_e s);
      return (s == ST_HLT) || (s == ST_ADR) || (s == ST_INS);
   endfunction
endpackage

// File: rtl/exc_fetch_stat.sv
module exc_fetch_stat
   import exc_pkg::*;
(
   input  logic  imem_err_i,
   input  logic  instr_valid_i,
   input  logic  halt_op_i,
   output stat_e stat_o
);
   always_comb begin
      if (imem_err_i)          stat_o = ST_ADR;
      else if (!instr_valid_i) stat_o = ST_INS;
      else if (halt_op_i)      stat_o = ST_HLT;
      else                     stat_o = ST_AOK;
   end
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
   import exc_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b0
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bubble_i,
   input  logic  stall_i,
   input  stat_e d_i,
   output stat_e q_o
);
   stat_e q_r;
   stat_e q_nxt;

   always_comb begin
      if (bubble_i)     q_nxt = ST_BUB;
      else if (stall_i) q_nxt = q_r;
      else              q_nxt = d_i;
   end

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= ST_BUB;
            else        q_r <= q_nxt;
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) q_r <= ST_BUB;
            else        q_r <= q_nxt;
         end
      end
   endgenerate

   assign q_o = q_r;

   // R8: bubble loads the empty code, even with a stall present
   p_bubble_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_i |=> (q_r == ST_BUB));

   // R8: stall alone keeps the register
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !bubble_i) |=> $stable(q_r));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
   import exc_pkg::*;
(
   input  stat_e m_q_i,
   input  stat_e w_q_i,
   input  logic  dmem_err_i,
   input  logic  e_aluop_i,
   input  logic  m_wr_req_i,
   output stat_e m_stat_o,
   output logic  set_cc_o,
   output logic  dmem_we_o,
   output logic  m_bubble_o,
   output logic  w_stall_o
);
   logic m_fault;
   logic w_fault;

   assign m_stat_o   = dmem_err_i ? ST_ADR : m_q_i;
   assign m_fault    = is_fault(m_stat_o);
   assign w_fault    = is_fault(w_q_i);
   assign set_cc_o   = e_aluop_i && !m_fault && !w_fault;
   assign dmem_we_o  = m_wr_req_i && !m_fault && !w_fault;
   assign m_bubble_o = m_fault || w_fault;
   assign w_stall_o  = w_fault;
endmodule

// File: rtl/exc_status_tracker.sv
module exc_status_tracker
   import exc_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b0,
   parameter int HZ_W      = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              imem_err_i,
   input  logic              instr_valid_i,
   input  logic              halt_op_i,
   input  logic              dmem_err_i,
   input  logic              e_aluop_i,
   input  logic              m_wr_req_i,
   input  logic [HZ_W-1:0]   hz_bubble_i,
   input  logic [HZ_W-1:0]   hz_stall_i,
   output logic              set_cc_o,
   output logic              dmem_we_o,
   output logic              m_bubble_o,
   output logic              w_stall_o,
   output logic [STAT_W-1:0] stat_o,
   output logic              halted_o
);
   generate
      if (HZ_W != NREG) begin : g_bad_hz_w
         $error("HZ_W must equal the number of stage registers");
      end
   endgenerate

   stat_e f_stat;
   stat_e m_stat;
   stat_e stat_rep;
   stat_e st_in [NREG];
   stat_e st_q  [NREG];
   logic  ctl_mbub;
   logic  ctl_wstall;
   logic  halt_q;
   logic  not_ok;

   exc_fetch_stat u_fetch (
      .imem_err_i    (imem_err_i),
      .instr_valid_i (instr_valid_i),
      .halt_op_i     (halt_op_i),
      .stat_o        (f_stat)
   );

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_stage
         logic bub;
         logic stl;
         if (i == IDX_D) begin : g_src_f
            assign st_in[i] = f_stat;
         end else if (i == IDX_W) begin : g_src_m
            assign st_in[i] = m_stat;
         end else begin : g_src_prev
            assign st_in[i] = st_q[i-1];
         end
         if (i == IDX_M) begin : g_mctl
            assign bub = hz_bubble_i[i] | ctl_mbub;
         end else begin : g_mnone
            assign bub = hz_bubble_i[i];
         end
         if (i == IDX_W) begin : g_wctl
            assign stl = hz_stall_i[i] | ctl_wstall;
         end else begin : g_wnone
            assign stl = hz_stall_i[i];
         end
         exc_stage_reg #(.ASYNC_RST(ASYNC_RST)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .bubble_i (bub),
            .stall_i  (stl),
            .d_i      (st_in[i]),
            .q_o      (st_q[i])
         );
      end
   endgenerate

   exc_ctrl u_ctrl (
      .m_q_i      (st_q[IDX_M]),
      .w_q_i      (st_q[IDX_W]),
      .dmem_err_i (dmem_err_i),
      .e_aluop_i  (e_aluop_i),
      .m_wr_req_i (m_wr_req_i),
      .m_stat_o   (m_stat),
      .set_cc_o   (set_cc_o),
      .dmem_we_o  (dmem_we_o),
      .m_bubble_o (ctl_mbub),
      .w_stall_o  (ctl_wstall)
   );

   assign stat_rep   = (st_q[IDX_W] == ST_BUB) ? ST_AOK : st_q[IDX_W];
   assign stat_o     = stat_rep;
   assign not_ok     = (stat_rep != ST_AOK);
   assign m_bubble_o = ctl_mbub;
   assign w_stall_o  = ctl_wstall;

   generate
      if (ASYNC_RST) begin : g_h_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) halt_q <= 1'b0;
            else        halt_q <= halt_q | not_ok;
         end
      end else begin : g_h_srst
         always_ff @(posedge clk) begin
            if (!rst_n) halt_q <= 1'b0;
            else        halt_q <= halt_q | not_ok;
         end
      end
   endgenerate

   assign halted_o = halt_q | not_ok;

   // R2: execute takes the decode code one edge later
   p_pass_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hz_bubble_i[IDX_E] && !hz_stall_i[IDX_E]) |=> (st_q[IDX_E] == $past(st_q[IDX_D])));

   // R4: bubble is never reported
   p_no_bub_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o != ST_BUB);

   // R5: a visible fault blocks condition codes
   p_cc_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o inside {ST_HLT, ST_ADR, ST_INS}) |-> !set_cc_o);

   // R6: a data memory error never coincides with a write
   p_dmem_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_err_i |-> !dmem_we_o);

   // R6: fault-driven bubble empties the memory register
   p_mbub_r6: assert property (@(posedge clk) disable iff (!rst_n)
      m_bubble_o |=> (st_q[IDX_M] == ST_BUB));

   // R7: the faulting code stays at write-back
   p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (w_stall_o && !hz_bubble_i[IDX_W]) |=> (stat_o == $past(stat_o)));

   // R9: halted is sticky
   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o);
endmodule

// File: tb/exc_status_tracker_tb.sv
module exc_status_tracker_tb;
   localparam int CLK_P = 10;
   localparam int NVEC  = 8;
   // {imem_err, invalid, halt, dmem_err, expected[2:0]}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b0000_001, 7'b1000_011, 7'b0100_100, 7'b0010_010,
      7'b0001_011, 7'b1100_011, 7'b0110_100, 7'b0011_011
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       imem_err_i, instr_valid_i, halt_op_i, dmem_err_i;
   logic       e_aluop_i, m_wr_req_i;
   logic [3:0] hz_bubble_i, hz_stall_i;
   logic       set_cc_o, dmem_we_o, m_bubble_o, w_stall_o, halted_o;
   logic [2:0] stat_o;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   exc_status_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .imem_err_i(imem_err_i), .instr_valid_i(instr_valid_i),
      .halt_op_i(halt_op_i), .dmem_err_i(dmem_err_i), .e_aluop_i(e_aluop_i),
      .m_wr_req_i(m_wr_req_i), .hz_bubble_i(hz_bubble_i), .hz_stall_i(hz_stall_i),
      .set_cc_o(set_cc_o), .dmem_we_o(dmem_we_o), .m_bubble_o(m_bubble_o),
      .w_stall_o(w_stall_o), .stat_o(stat_o), .halted_o(halted_o)
   );

   function automatic bit flt(logic [2:0] s);
      return (s == 3'd2) || (s == 3'd3) || (s == 3'd4);
   endfunction

   task automatic tick();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic defaults();
      imem_err_i = 0; instr_valid_i = 1; halt_op_i = 0; dmem_err_i = 0;
      e_aluop_i = 1; m_wr_req_i = 1; hz_bubble_i = 0; hz_stall_i = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      defaults();
      tick();
      tick();
      rst_n = 1;
   endtask

   initial begin
      #(CLK_P*50000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // reset state: R4, R5, R6, R7, R9
      do_reset();
      #1;
      chk("R4 reset status OK", stat_o, 1);
      chk("R9 reset halted low", halted_o, 0);
      chk("R7 reset no stall", w_stall_o, 0);
      chk("R6 reset no bubble", m_bubble_o, 0);
      chk("R5 cc with aluop", set_cc_o, 1);
      chk("R6 we follows request", dmem_we_o, 1);
      e_aluop_i = 0; m_wr_req_i = 0;
      #1;
      chk("R5 cc without aluop", set_cc_o, 0);
      chk("R6 we without request", dmem_we_o, 0);
      defaults();

      // vector walk: R1, R2, R3, R5, R6, R7, R9
      for (int v = 0; v < NVEC; v++) begin
         logic [2:0] ex;
         ex = VEC[v][2:0];
         do_reset();
         imem_err_i = VEC[v][6]; instr_valid_i = ~VEC[v][5]; halt_op_i = VEC[v][4];
         tick();
         defaults();
         tick();
         tick();
         dmem_err_i = VEC[v][3];
         #1;
         chk($sformatf("R4 v%0d empty wb shows OK", v), stat_o, 1);
         chk($sformatf("R5 v%0d cc in mem cycle", v), set_cc_o, !flt(ex));
         chk($sformatf("R6 v%0d bubble in mem cycle", v), m_bubble_o, flt(ex));
         chk($sformatf("R6 v%0d we in mem cycle", v), dmem_we_o, !flt(ex));
         tick();
         dmem_err_i = 0;
         #1;
         chk($sformatf("R1 R2 R3 v%0d status", v), stat_o, ex);
         chk($sformatf("R7 v%0d wb stall", v), w_stall_o, flt(ex));
         chk($sformatf("R5 v%0d cc with wb code", v), set_cc_o, !flt(ex));
         chk($sformatf("R6 v%0d we with wb code", v), dmem_we_o, !flt(ex));
         chk($sformatf("R9 v%0d halted", v), halted_o, flt(ex));
         tick();
         #1;
         chk($sformatf("R7 v%0d status held", v), stat_o, ex);
      end

      // R8: stall on D, E, M delays an illegal code by two edges
      do_reset();
      instr_valid_i = 0;
      tick();
      defaults();
      tick();
      hz_stall_i = 4'b0111;
      tick();
      tick();
      #1;
      chk("R8 stall keeps wb empty", stat_o, 1);
      hz_stall_i = 0;
      tick();
      #1;
      chk("R8 stall delay one", stat_o, 1);
      tick();
      #1;
      chk("R8 stalled code arrives", stat_o, 4);

      // R8: bubble beats stall on execute
      do_reset();
      instr_valid_i = 0;
      tick();
      defaults();
      tick();
      hz_stall_i = 4'b0111; hz_bubble_i = 4'b0010;
      tick();
      hz_bubble_i = 0;
      tick();
      hz_stall_i = 0;
      tick();
      tick();
      #1;
      chk("R8 bubble wins code dropped", stat_o, 1);
      chk("R8 bubble wins not halted", halted_o, 0);

      // R9: halted stays after the fault is cleared by a wb bubble
      do_reset();
      halt_op_i = 1;
      tick();
      defaults();
      tick(); tick(); tick();
      #1;
      chk("R1 halt reaches wb", stat_o, 2);
      chk("R9 halted set", halted_o, 1);
      hz_bubble_i = 4'b1000;
      tick();
      hz_bubble_i = 0;
      #1;
      chk("R8 wb bubble over fault stall", stat_o, 1);
      chk("R9 halted after clear", halted_o, 1);
      tick();
      #1;
      chk("R9 halted sticky", halted_o, 1);
      chk("R7 stall released", w_stall_o, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule